// File: doc/BRIEF.md
# Prioritised Autovector Interrupt Encoder

This block gathers seven active-high interrupt request lines, numbered 1 to 7, and a non-maskable request. It reduces them to the single highest-priority pending line. It presents that line to a processor as a 3-bit priority level and an 8-bit autovector number. The vector is a fixed base of 24 plus the level, so levels 1 to 7 map to vectors 25 to 31. The non-maskable request is folded onto line 7, the top line. It behaves exactly as if line 7 itself were driven high.

Each line keeps a 32-bit count of how many times it has gone from low to high. A plain combinational read port exposes the pending bits and the counters. The read port has no handshake: the address selects a word, and the word appears on the data output in the same cycle. The level and vector outputs are registered. They follow the request inputs one clock later. An active-low asynchronous reset clears all state.

Top module: `irq_autovec_enc`

## Requirements
- R1: While `rst_n` is low, all pending bits, all counters, `ipl_o` and `vec_o` are zero.
- R2: Pending bit k (line k+1) is 1 one clock after line k+1 is high, and 0 one clock after it is low.
- R3: When several lines are pending, `ipl_o` gives the number of the highest-numbered one; line 7 beats every other line.
- R4: With a line pending, `vec_o` equals 24 plus `ipl_o`, so levels 1..7 give vectors 25..31.
- R5: With no line pending, `ipl_o` and `vec_o` are both 0.
- R6: A high `nmi_req` makes line 7 pending and selects level 7, exactly as a high line 7 would.
- R7: A line's counter rises by one on each low-to-high change of that line (line 7 counting line 7 OR `nmi_req`) and does not change while the line stays high or low.
- R8: `ipl_o` and `vec_o` change only on a clock edge: after an input change they keep their old value until the next rising clock edge, then show the new result.
- R9: `rd_addr` 0 returns the pending bits in `rd_data[6:0]` (bit k is line k+1), with the upper bits zero. `rd_addr` k in 1..7 returns the counter of line k. The reset-cleared counters are read here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 7 | Request lines; bit k is line k+1 |
| nmi_req | input | 1 | Non-maskable request, merged onto line 7 |
| rd_addr | input | 3 | Read select: 0 pending bits, 1..7 line counter |
| rd_data | output | 32 | Selected read word |
| ipl_o | output | 3 | Registered priority level, 0 when idle |
| vec_o | output | 8 | Registered autovector number, 0 when idle |

## Verification
The assertions assume the request inputs are synchronous to `clk`. They also assume the inputs stay stable around each rising edge, so every line is seen at a clock edge. The bench changes every input only on the falling edge. Each request pattern is held for at least one full clock, so no pulse slips between edges unseen. The sweep walks all 256 combinations of lines and non-maskable request. It also covers hold periods and a reset in mid-run, which stays within those input assumptions.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned DEF_LINES    = 7;
  localparam int unsigned DEF_CNT_W    = 32;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_VEC_BASE = 24;
endpackage

// File: rtl/irq_line_ctr.sv
module irq_line_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             pend_q,
  output logic [CNT_W-1:0] rise_cnt_q
);
  logic rise;
  assign rise = line_in & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      rise_cnt_q <= '0;
    end else begin
      pend_q <= line_in;
      if (rise) rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_LINES = 7,
  localparam int unsigned LVL_W  = $clog2(N_LINES + 1)
) (
  input  logic [N_LINES-1:0] active,
  output logic [LVL_W-1:0]   level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < int'(N_LINES); i++) begin
      if (active[i]) level = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_autovec_enc.sv
module irq_autovec_enc
  import irq_enc_pkg::*;
#(
  parameter int unsigned N_LINES  = DEF_LINES,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned VEC_BASE = DEF_VEC_BASE,
  localparam int unsigned LVL_W   = $clog2(N_LINES + 1),
  localparam int unsigned ADDR_W  = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               nmi_req,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [LVL_W-1:0]   ipl_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [N_LINES-1:0] eff_req;
  logic [N_LINES-1:0] pend;
  logic [CNT_W-1:0]   cnt_a [N_LINES];
  logic [LVL_W-1:0]   lvl_nxt;
  logic [VEC_W-1:0]   vec_nxt;

  assign eff_req = irq_req | {nmi_req, {(N_LINES-1){1'b0}}};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_ctr #(.CNT_W(CNT_W)) line_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (eff_req[g]),
      .pend_q     (pend[g]),
      .rise_cnt_q (cnt_a[g])
    );
  end

  irq_prio_pick #(.N_LINES(N_LINES)) pick_i (
    .active (eff_req),
    .level  (lvl_nxt)
  );

  assign vec_nxt = (lvl_nxt == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(lvl_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_o <= '0;
      vec_o <= '0;
    end else begin
      ipl_o <= lvl_nxt;
      vec_o <= vec_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = CNT_W'(pend);
    for (int k = 0; k < int'(N_LINES); k++) begin
      if (rd_addr == ADDR_W'(k + 1)) rd_data = cnt_a[k];
    end
  end
endmodule

// File: rtl/irq_autovec_chk.sv
module irq_autovec_chk #(
  parameter int unsigned N_LINES  = 7,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 24,
  localparam int unsigned LVL_W   = $clog2(N_LINES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_req,
  input logic               nmi_req,
  input logic [LVL_W-1:0]   ipl_o,
  input logic [VEC_W-1:0]   vec_o
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (ipl_o == '0 && vec_o == '0));

  p_top_line_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[N_LINES-1] |=> ipl_o == LVL_W'(N_LINES));

  p_vec_tracks_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_o != '0) |-> vec_o == VEC_W'(VEC_BASE) + VEC_W'(ipl_o));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0 && !nmi_req) |=> (ipl_o == '0 && vec_o == '0));

  p_nmi_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> ipl_o == LVL_W'(N_LINES));

  p_any_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |=> ipl_o != '0);
endmodule

bind irq_autovec_enc irq_autovec_chk #(
  .N_LINES(N_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
  .ipl_o(ipl_o), .vec_o(vec_o)
);

// File: tb/irq_autovec_enc_tb.sv
module irq_autovec_enc_tb_top;
  localparam int CLK_P = 10;
  localparam int NL = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_req = '0;
  logic        nmi_req = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  ipl_o;
  logic [7:0]  vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned mcnt [NL];
  logic [6:0] mprev = '0;
  int exp_lvl = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_autovec_enc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .ipl_o(ipl_o), .vec_o(vec_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int top_level(input logic [6:0] e);
    int l = 0;
    for (int i = 0; i < NL; i++) if (e[i]) l = i + 1;
    return l;
  endfunction

  // drive at negedge, update model, check R8 before edge, check result after
  task automatic apply(input logic [6:0] r, input logic n, input string tag);
    logic [6:0] e;
    int old_lvl;
    @(negedge clk);
    irq_req = r;
    nmi_req = n;
    e = r | {n, 6'b0};
    old_lvl = exp_lvl;
    #1;
    chk({tag, " R8 level held before edge"}, ipl_o, old_lvl);
    for (int i = 0; i < NL; i++) if (e[i] && !mprev[i]) mcnt[i]++;
    mprev = e;
    exp_lvl = top_level(e);
    @(negedge clk);
    chk({tag, " R3 level"}, ipl_o, exp_lvl);
    chk({tag, " R4/R5 vector"}, vec_o, (exp_lvl == 0) ? 0 : 24 + exp_lvl);
    rd_addr = 3'd0;
    #1;
    chk({tag, " R2/R6/R9 pending"}, rd_data, {25'b0, e});
  endtask

  task automatic check_counters(input string tag);
    for (int k = 1; k <= NL; k++) begin
      rd_addr = 3'(k);
      #1;
      chk({tag, " R7/R9 counter"}, rd_data, mcnt[k-1]);
    end
    rd_addr = 3'd0;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) mcnt[i] = 0;
    #(CLK_P*2 + 2);
    // R1: reset state
    chk("R1 level in reset", ipl_o, 0);
    chk("R1 vector in reset", vec_o, 0);
    rd_addr = 3'd0; #1;
    chk("R1 pending in reset", rd_data, 0);
    check_counters("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive sweep of lines x nmi
    for (int p = 0; p < 256; p++) apply(7'(p), p[7], "sweep");
    check_counters("sweep");

    // R7: hold high several cycles, count once
    apply(7'h00, 1'b0, "clear");
    apply(7'h05, 1'b0, "hold");
    repeat (5) @(negedge clk);
    chk("R7 held level", ipl_o, 3);
    check_counters("hold");
    // R6: nmi while line 7 already high does not recount
    apply(7'h40, 1'b0, "l7");
    apply(7'h40, 1'b1, "l7+nmi");
    apply(7'h00, 1'b1, "nmi only");
    apply(7'h00, 1'b0, "drop");
    check_counters("nmi merge");

    // R1: reset mid-run
    apply(7'h7f, 1'b0, "all");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 level after mid reset", ipl_o, 0);
    chk("R1 vector after mid reset", vec_o, 0);
    for (int i = 0; i < NL; i++) mcnt[i] = 0;
    check_counters("R1 mid reset");
    irq_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    mprev = '0;
    exp_lvl = 0;
    apply(7'h01, 1'b0, "after reset");
    check_counters("after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule